// File: doc/BRIEF.md
# Serial Audio Link Power-Down and Wake Controller

This block sits on the codec side of a serial audio link. It receives register writes that an upstream frame decoder has already pulled out of the output frame, as an address and a data word. It holds the small set of control registers that those writes target. When software sets the low-power bit in the power-down register, the block stops its bit clock and forces the serial input data line low. Both stay low until the controller wakes the link.

There are two ways to wake the link. A cold reset uses the asynchronous active-low reset pin and returns every register to its default value. A warm reset works only while the clock is stopped: the controller holds SYNC high for a qualifying time and then drops it. The clock restarts on that falling edge. A warm reset keeps all register contents, and so does the power-down period itself. A write to the reset register address restores the defaults without touching the link.

After any restart, the block counts a fixed number of bit-clock rising edges. It then raises the codec-ready flag, which feeds bit 15 of input slot 0.

Top module: `link_pm`

## Requirements
- R1: While `cold_rst_n` is low, `bit_clk_o` and `codec_ready_o` are 0. Each bank register reads 16'h8000 and the power-down register (address 7'h26) reads 16'h0000.
- R2: While the link runs, `bit_clk_o` toggles every DIV core clock cycles. It starts low, and its first rise comes DIV cycles after the restart edge.
- R3: `codec_ready_o` rises on the core clock edge that produces the READY_BCLK-th rising edge of `bit_clk_o` after a restart. A restart is a reset release or a warm wake.
- R4: A write to address 7'h26 with data bit 12 set is stored. On the next edge it stops the link: `bit_clk_o`, `codec_ready_o` and `sdin_o` go to 0 and stay at 0.
- R5: A write to address 7'h26 with bit 12 clear is stored and readable, and the link keeps running.
- R6: `sdin_o` equals `sdin_raw_i` while the link runs and is 0 while it is stopped.
- R7: While the link is stopped, register writes have no effect on any register.
- R8: While the link is stopped, SYNC sampled high on WARM_CYC consecutive edges arms a warm wake. The clock restarts on the first edge that then samples SYNC low. A shorter high pulse leaves the link stopped.
- R9: Bank registers (addresses 7'h02, 7'h04, 7'h06, 7'h08) and the power-down register keep their values across power-down and warm wake.
- R10: A write to address 7'h00 (data ignored) restores all register defaults and does not disturb the bit clock or the ready flag.
- R11: A cold reset asserted while the link is stopped restarts the link and restores the register defaults.
- R12: A read of any address other than the bank addresses and 7'h26 returns 0. Address 7'h00 also reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock from which the bit clock is divided |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset |
| sync_i | input | 1 | SYNC line from the controller |
| wr_valid_i | input | 1 | Decoded register write strobe |
| wr_addr_i | input | 7 | Decoded register write address |
| wr_data_i | input | 16 | Decoded register write data |
| sdin_raw_i | input | 1 | Serial input data from the frame builder, before gating |
| rd_addr_i | input | 7 | Register read address |
| bit_clk_o | output | 1 | Bit clock to the link |
| sdin_o | output | 1 | Gated serial input data line |
| codec_ready_o | output | 1 | Codec-ready flag for input slot 0 bit 15 |
| rd_data_o | output | 16 | Register read data (combinational) |

## Verification
A state machine stuck in, or wrongly left in, the stopped state shows up on `bit_clk_o` within DIV cycles, because the expected toggle never comes. It shows up on `sdin_o` in the same cycle. An early or late wake shows up as a clock edge that is off by whole cycles relative to the falling SYNC edge. A miscounted ready counter moves the `codec_ready_o` rise by at least 2*DIV cycles. A lost or spurious register update stays hidden until the register is read. For that reason the bench reads every register after each power transition and each write.

// File: rtl/link_pm.sv
module link_pm #(
  parameter int DW = 16,
  parameter int AW = 7,
  parameter int NREG = 4,
  parameter int DIV = 2,
  parameter int READY_BCLK = 16,
  parameter int WARM_CYC = 200,
  parameter int PD_BIT = 12,
  parameter logic [AW-1:0] PD_ADDR = 7'h26,
  parameter logic [AW-1:0] RST_ADDR = 7'h00,
  parameter logic [AW-1:0] BANK_BASE = 7'h02,
  parameter logic [DW-1:0] BANK_DEFAULT = 16'h8000
) (
  input  logic          clk,
  input  logic          cold_rst_n,
  input  logic          sync_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sdin_raw_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          bit_clk_o,
  output logic          sdin_o,
  output logic          codec_ready_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int DCW = $clog2(DIV + 1);
  localparam int RCW = $clog2(READY_BCLK + 1);
  localparam int WCW = $clog2(WARM_CYC + 1);

  typedef enum logic [1:0] {S_RUN, S_DOWN, S_ARMED} st_t;

  st_t                      state;
  logic [DCW-1:0]           dcnt;
  logic [RCW-1:0]           rcnt;
  logic [WCW-1:0]           wcnt;
  logic                     bclk;
  logic                     ready;
  logic [DW-1:0]            pd_q;
  logic [NREG-1:0][DW-1:0]  bank;

  wire running  = (state == S_RUN);
  wire wr_ok    = running && wr_valid_i;
  wire pd_hit   = wr_ok && (wr_addr_i == PD_ADDR);
  wire pd_enter = pd_hit && wr_data_i[PD_BIT];
  wire rst_hit  = wr_ok && (wr_addr_i == RST_ADDR);
  wire tick     = running && (dcnt == DCW'(DIV - 1));
  wire rise     = tick && !bclk;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      state <= S_RUN;
      dcnt  <= '0;
      bclk  <= 1'b0;
      rcnt  <= '0;
      ready <= 1'b0;
      wcnt  <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (pd_enter) begin
            state <= S_DOWN;
            dcnt  <= '0;
            bclk  <= 1'b0;
            rcnt  <= '0;
            ready <= 1'b0;
            wcnt  <= '0;
          end else begin
            if (tick) begin
              dcnt <= '0;
              bclk <= ~bclk;
            end else begin
              dcnt <= dcnt + 1'b1;
            end
            if (rise && !ready) begin
              if (rcnt == RCW'(READY_BCLK - 1)) ready <= 1'b1;
              else rcnt <= rcnt + 1'b1;
            end
          end
        end
        S_DOWN: begin
          if (sync_i) begin
            if (wcnt == WCW'(WARM_CYC - 1)) state <= S_ARMED;
            else wcnt <= wcnt + 1'b1;
          end else begin
            wcnt <= '0;
          end
        end
        S_ARMED: begin
          if (!sync_i) begin
            state <= S_RUN;
            wcnt  <= '0;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)  pd_q <= '0;
    else if (rst_hit) pd_q <= '0;
    else if (pd_hit)  pd_q <= wr_data_i;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(BANK_BASE + 2 * i);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)  q <= BANK_DEFAULT;
      else if (rst_hit) q <= BANK_DEFAULT;
      else if (wr_ok && wr_addr_i == MY_ADDR) q <= wr_data_i;
    end
    assign bank[i] = q;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == PD_ADDR) rd_data_o = pd_q;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == AW'(BANK_BASE + 2 * i)) rd_data_o = bank[i];
  end

  assign bit_clk_o     = bclk;
  assign sdin_o        = running & sdin_raw_i;
  assign codec_ready_o = ready;
endmodule

// File: rtl/link_pm_chk.sv
module link_pm_chk #(
  parameter int DW = 16,
  parameter int AW = 7,
  parameter int NREG = 4,
  parameter int PD_BIT = 12,
  parameter logic [AW-1:0] PD_ADDR = 7'h26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             sync_i,
  input logic             wr_valid_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic             bit_clk_o,
  input logic             sdin_o,
  input logic             codec_ready_o,
  input logic [NREG*DW-1:0] regs_flat,
  input logic [DW-1:0]    pd_q
);
  assert_clk_low_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !bit_clk_o);

  assert_ready_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    codec_ready_o |-> running);

  assert_sdin_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sdin_o);

  assert_pd_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_valid_i && wr_addr_i == PD_ADDR && wr_data_i[PD_BIT]) |=> !running);

  assert_regs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> ($stable(regs_flat) && $stable(pd_q)));

  assert_wake_on_sync_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !$past(sync_i));
endmodule

bind link_pm link_pm_chk #(
  .DW(DW), .AW(AW), .NREG(NREG), .PD_BIT(PD_BIT), .PD_ADDR(PD_ADDR)
) u_chk (
  .clk(clk), .rst_n(cold_rst_n), .running(running), .sync_i(sync_i),
  .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .bit_clk_o(bit_clk_o), .sdin_o(sdin_o), .codec_ready_o(codec_ready_o),
  .regs_flat(bank), .pd_q(pd_q)
);

// File: tb/sim_link_pm.sv
`timescale 1ns/1ps
module sim_link_pm;
  localparam int DIV = 2;
  localparam int RB = 16;
  localparam int WARM = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic wv = 1'b0;
  logic [6:0] wa = '0;
  logic [15:0] wd = '0;
  logic raw = 1'b0;
  logic [6:0] ra = '0;
  logic bclk, sdin, rdy;
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  link_pm u0 (
    .clk(clk), .cold_rst_n(rst_n), .sync_i(sync), .wr_valid_i(wv),
    .wr_addr_i(wa), .wr_data_i(wd), .sdin_raw_i(raw), .rd_addr_i(ra),
    .bit_clk_o(bclk), .sdin_o(sdin), .codec_ready_o(rdy), .rd_data_o(rd)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  int t, ms, wc;
  logic [15:0] mb [4];
  logic [15:0] mpd;

  function automatic void mdef();
    for (int i = 0; i < 4; i++) mb[i] = 16'h8000;
    mpd = 16'h0000;
  endfunction

  function automatic void mreset();
    mdef();
    ms = 0; t = 0; wc = 0;
  endfunction

  function automatic void mwrite();
    if (wa == 7'h00) mdef();
    else if (wa == 7'h26) mpd = wd;
    else for (int i = 0; i < 4; i++) if (wa == 7'(2 + 2 * i)) mb[i] = wd;
  endfunction

  function automatic logic [15:0] e_rd();
    logic [15:0] v = 16'h0000;
    if (ra == 7'h26) v = mpd;
    for (int i = 0; i < 4; i++) if (ra == 7'(2 + 2 * i)) v = mb[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else begin
      case (ms)
        0: begin
          if (wv && wa == 7'h26 && wd[12]) begin
            mpd = wd; ms = 1; t = 0; wc = 0;
          end else begin
            if (wv) mwrite();
            t++;
          end
        end
        1: begin
          if (sync) begin
            if (wc == WARM - 1) ms = 2; else wc++;
          end else wc = 0;
        end
        default: if (!sync) begin ms = 0; t = 0; end
      endcase
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("bit_clk", {15'd0, bclk}, {15'd0, (ms == 0) && ((t / DIV) % 2 == 1)});
    chk("ready", {15'd0, rdy}, {15'd0, (ms == 0) && (t >= DIV * (2 * RB - 1))});
    chk("sdin", {15'd0, sdin}, {15'd0, (ms == 0) && raw});
    chk("rd_data", rd, e_rd());
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    wv = 1'b1; wa = a; wd = d;
    idle(1);
    wv = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    mreset();
    ra = 7'h02;
    idle(4);
    ra = 7'h26;
    idle(2);
    rst_n = 1'b1;
    phase = "R2"; idle(20);
    phase = "R3"; idle(60);
    phase = "R6";
    for (int i = 0; i < 10; i++) begin raw = i[0] ^ i[2]; idle(1); end
    phase = "R5";
    wr(7'h26, 16'h0300); idle(3);
    wr(7'h02, 16'h1234); wr(7'h04, 16'h5678); wr(7'h06, 16'h9abc); wr(7'h08, 16'hdef0);
    for (int i = 0; i < 4; i++) begin ra = 7'(2 + 2 * i); idle(2); end
    phase = "R12";
    ra = 7'h0a; idle(2); ra = 7'h03; idle(2); ra = 7'h7f; idle(2); ra = 7'h00; idle(2);
    phase = "R4";
    raw = 1'b1; ra = 7'h26;
    wr(7'h26, 16'h1300); idle(12);
    phase = "R7";
    wr(7'h02, 16'hffff); wr(7'h26, 16'h0000); wr(7'h00, 16'h0000);
    ra = 7'h02; idle(2); ra = 7'h26; idle(2);
    phase = "R8";
    sync = 1'b1; idle(50); sync = 1'b0; idle(20);
    sync = 1'b1; idle(WARM + 20); sync = 1'b0; idle(10);
    phase = "R3"; idle(70);
    phase = "R9";
    for (int i = 0; i < 4; i++) begin ra = 7'(2 + 2 * i); idle(2); end
    ra = 7'h26; idle(2);
    phase = "R10";
    wr(7'h00, 16'h5a5a); ra = 7'h04; idle(2); ra = 7'h26; idle(4);
    phase = "R11";
    wr(7'h06, 16'h4321); wr(7'h26, 16'h1000); idle(6);
    rst_n = 1'b0; mreset(); ra = 7'h06; idle(3);
    rst_n = 1'b1; idle(70);
    ra = 7'h26; idle(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog %s run did not finish", phase);
      summary();
      $finish;
    end
  end
endmodule